// File: doc/BRIEF.md
# Time-Hopping Binary Pulse-Position Modulator

This block sits on the transmit side of an optical link where several users share the medium by time hopping. Each data bit fills one symbol period. The period is cut into a configurable number of slots, and each slot lasts `2*H` clock cycles. A 7-bit maximum-length shift register picks the slots this user may occupy. Inside an occupied slot the bit is carried by binary pulse position: the pulse sits in one half of the slot or in the other. A configured pulse budget caps how many occupied slots carry a pulse in each symbol. Every other slot stays dark so that other users can use it.

Bits arrive over a valid/ready handshake. The block offers ready only in the first cycle of each symbol, and it samples the configuration word in that same cycle. The pulse drive, the symbol strobe and the configuration error flag are registered outputs. All three run one cycle behind the internal slot timer.

Top module: `th_ppm_mod`

## Requirements
- R1: In the cycle after reset is released, `bit_ready` is 1 and `pulse_out`, `sym_strobe` and `cfg_err` are 0.
- R2: `bit_ready` is 1 only in the first timer cycle of a symbol. A symbol lasts `S*2*H` cycles, where S is the effective slot count. A bit is taken when `bit_valid` and `bit_ready` are both 1.
- R3: `sym_strobe` is 1 for exactly one cycle, the cycle after the one in which ready was offered. That cycle is the first output cycle of the symbol.
- R4: In an occupied slot, a bit of 0 drives `pulse_out` high for output cycles 0..H-1 of the slot. A bit of 1 drives it high for cycles H..2H-1. Each pulse lasts exactly H cycles.
- R5: The slot selector is a 7-bit register s. It steps once per slot to {s[5:0], s[6]^s[5]}. Bit s[6] marks the current slot as occupied. After reset, s holds `seed`, except that a seed of zero is replaced by 7'h01. The register keeps stepping across symbols and never returns to zero.
- R6: At most P occupied slots carry a pulse in a symbol, where P is `cfg_word[7:4]`. Once P pulses have been sent, the remaining slots of that symbol stay dark.
- R7: If no bit is taken at the start of a symbol, that symbol is sent dark. The slot timing and the selector stepping go on as usual.
- R8: Let N be `cfg_word[3:0]`. When N is 0 or N < P, `cfg_err` is 1 for that symbol. In that case the symbol has max(P,1) slots and every slot is treated as occupied, still within the budget P. Otherwise S = N and `cfg_err` is 0.
- R9: The configuration is sampled only in the cycle in which ready is offered. Changes to it later in the symbol have no effect on that symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the selector from `seed` |
| bit_in | input | 1 | Data bit |
| bit_valid | input | 1 | Data bit is valid |
| bit_ready | output | 1 | Block takes a bit in this cycle |
| cfg_word | input | 2*SLOT_W | [SLOT_W-1:0] slots per symbol, [2*SLOT_W-1:SLOT_W] pulse budget |
| seed | input | 7 | Selector start value used during reset |
| pulse_out | output | 1 | Optical pulse drive |
| sym_strobe | output | 1 | One-cycle mark at the first output cycle of each symbol |
| cfg_err | output | 1 | Configuration of the current symbol was invalid and has been clamped |

## Verification
The bench models the selector itself and compares `pulse_out` against that model in every cycle, over several symbols in a row. A wrong tap, a wrong output bit or a selector that restarts per symbol would therefore put pulses in the wrong slots. The pulse budget is tested both at zero and with enough slots that the budget cuts off late occupied slots; a design that ignored the budget would emit extra pulses. Invalid configurations (fewer slots than pulses, zero slots) are driven to check the clamped symbol length and the forced occupancy; a design that got this wrong would offer ready at the wrong time. The bench also changes the configuration in the middle of a symbol, sends a symbol with no valid bit, and resets with a zero seed. Each of these would expose a design that samples late, emits pulses without data, or locks up at zero.

// File: rtl/th_ppm_pkg.sv
package th_ppm_pkg;
    localparam int LFSR_W = 7;
    typedef logic [LFSR_W-1:0] lfsr_t;
    localparam lfsr_t LFSR_ZERO_SUB = 7'h01;
endpackage

// File: rtl/th_lfsr_step.sv
module th_lfsr_step
    import th_ppm_pkg::*;
(
    input  lfsr_t cur,
    input  logic  adv,
    output lfsr_t nxt,
    output logic  occ_bit
);
    logic fb;

    // x^7 + x^6 + 1: feedback from the two top stages
    assign fb      = cur[LFSR_W-1] ^ cur[LFSR_W-2];
    assign nxt     = adv ? {cur[LFSR_W-2:0], fb} : cur;
    assign occ_bit = cur[LFSR_W-1];
endmodule

// File: rtl/th_cfg_sanitize.sv
module th_cfg_sanitize #(
    parameter int SLOT_W = 4
) (
    input  logic [2*SLOT_W-1:0] word,
    output logic [SLOT_W-1:0]   slots_eff,
    output logic [SLOT_W-1:0]   pulses,
    output logic                err
);
    logic [SLOT_W-1:0] slots_req;

    assign slots_req = word[SLOT_W-1:0];
    assign pulses    = word[2*SLOT_W-1:SLOT_W];
    assign err       = (slots_req == '0) || (slots_req < pulses);

    always_comb begin
        if (!err)
            slots_eff = slots_req;
        else if (pulses == '0)
            slots_eff = SLOT_W'(1);
        else
            slots_eff = pulses;
    end
endmodule

// File: rtl/th_ppm_mod.sv
module th_ppm_mod
    import th_ppm_pkg::*;
#(
    parameter int H      = 4,
    parameter int SLOT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_in,
    input  logic                bit_valid,
    output logic                bit_ready,
    input  logic [2*SLOT_W-1:0] cfg_word,
    input  logic [LFSR_W-1:0]   seed,
    output logic                pulse_out,
    output logic                sym_strobe,
    output logic                cfg_err
);
    localparam int SLOT_LEN = 2 * H;
    localparam int PH_W     = (SLOT_LEN > 2) ? $clog2(SLOT_LEN) : 1;

    typedef struct packed {
        logic [PH_W-1:0]   phase;
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] used;
        logic [SLOT_W-1:0] slots;
        logic [SLOT_W-1:0] pulses;
        lfsr_t             lfsr;
        logic              active;
        logic              bitv;
        logic              err;
        logic              pulse;
        logic              strobe;
    } state_t;

    state_t q_q, q_d;

    logic [SLOT_W-1:0] san_slots, san_pulses;
    logic              san_err;
    logic              slot_end;
    lfsr_t             lfsr_nxt;
    logic              occ_bit;
    lfsr_t             lfsr_cur;

    th_cfg_sanitize #(.SLOT_W(SLOT_W)) i_cfg (
        .word      (cfg_word),
        .slots_eff (san_slots),
        .pulses    (san_pulses),
        .err       (san_err)
    );

    th_lfsr_step i_lfsr (
        .cur     (q_q.lfsr),
        .adv     (slot_end),
        .nxt     (lfsr_nxt),
        .occ_bit (occ_bit)
    );

    assign slot_end = (q_q.phase == PH_W'(SLOT_LEN - 1));
    assign lfsr_cur = q_q.lfsr;

    logic              start;
    logic [SLOT_W-1:0] slots_cur, pulses_cur, used_cur;
    logic              err_cur, active_cur, bit_cur, occ, sym_end, second_half;

    always_comb begin
        start       = (q_q.phase == '0) && (q_q.slot == '0);
        slots_cur   = start ? san_slots  : q_q.slots;
        pulses_cur  = start ? san_pulses : q_q.pulses;
        err_cur     = start ? san_err    : q_q.err;
        active_cur  = start ? bit_valid  : q_q.active;
        bit_cur     = start ? bit_in     : q_q.bitv;
        used_cur    = start ? '0         : q_q.used;
        sym_end     = slot_end && (q_q.slot == slots_cur - SLOT_W'(1));
        occ         = active_cur && (err_cur || occ_bit) && (used_cur < pulses_cur);
        second_half = (q_q.phase >= PH_W'(H));

        q_d        = q_q;
        q_d.slots  = slots_cur;
        q_d.pulses = pulses_cur;
        q_d.err    = err_cur;
        q_d.active = active_cur;
        q_d.bitv   = bit_cur;
        q_d.used   = slot_end ? used_cur + SLOT_W'(occ) : used_cur;
        q_d.lfsr   = lfsr_nxt;
        q_d.pulse  = occ && (second_half == bit_cur);
        q_d.strobe = start;
        q_d.phase  = slot_end ? '0 : q_q.phase + PH_W'(1);
        if (sym_end)
            q_d.slot = '0;
        else if (slot_end)
            q_d.slot = q_q.slot + SLOT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q        <= '0;
            q_q.lfsr   <= (seed == '0) ? LFSR_ZERO_SUB : seed;
        end else begin
            q_q <= q_d;
        end
    end

    assign bit_ready  = (q_q.phase == '0) && (q_q.slot == '0);
    assign pulse_out  = q_q.pulse;
    assign sym_strobe = q_q.strobe;
    assign cfg_err    = q_q.err;
endmodule

// File: rtl/th_ppm_chk.sv
module th_ppm_chk
    import th_ppm_pkg::*;
#(
    parameter int H = 4
) (
    input logic  clk,
    input logic  rst_n,
    input logic  bit_ready,
    input logic  sym_strobe,
    input logic  pulse_out,
    input logic  cfg_err,
    input lfsr_t lfsr_st
);
    localparam int RUN_W = $clog2(2 * H + 2) + 1;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (pulse_out)
            run_q <= run_q + RUN_W'(1);
        else
            run_q <= '0;
    end

    // R2
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ready |=> !bit_ready);

    // R3
    strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ready |=> sym_strobe);

    // R3
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_strobe |-> $past(bit_ready));

    // R8
    err_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_err) |-> sym_strobe);

    // R5
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_st != '0);

    // R4
    pulse_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> (run_q < RUN_W'(2 * H)));
endmodule

bind th_ppm_mod th_ppm_chk #(.H(H)) i_th_ppm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_ready  (bit_ready),
    .sym_strobe (sym_strobe),
    .pulse_out  (pulse_out),
    .cfg_err    (cfg_err),
    .lfsr_st    (lfsr_cur)
);

// File: tb/test_th_ppm_mod.sv
`timescale 1ns/1ps
module test_th_ppm_mod;
    localparam int H      = 3;
    localparam int SLOT_W = 4;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       bit_in = 0;
    logic       bit_valid = 0;
    logic       bit_ready;
    logic [7:0] cfg_word = 8'h00;
    logic [6:0] seed = 7'h55;
    logic       pulse_out, sym_strobe, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] m_lfsr;

    always #2.5 clk = ~clk;

    th_ppm_mod #(.H(H), .SLOT_W(SLOT_W)) i_th_ppm_mod (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .bit_ready(bit_ready), .cfg_word(cfg_word), .seed(seed),
        .pulse_out(pulse_out), .sym_strobe(sym_strobe), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R1 reset state; R5 seed load (zero replaced by 7'h01)
    task automatic t_reset(input logic [6:0] s);
        @(negedge clk);
        rst_n = 0; seed = s; bit_valid = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 ready", int'(bit_ready), 1);
        chk("R1 pulse", int'(pulse_out), 0);
        chk("R1 strobe", int'(sym_strobe), 0);
        chk("R1 err", int'(cfg_err), 0);
        m_lfsr = (s == 7'h00) ? 7'h01 : s;
    endtask

    // One symbol: called at a negedge where ready is high, returns at the next such negedge
    task automatic t_sym(input logic b, input logic v, input int sl, input int pl,
                         input logic scramble, input string req);
        logic err;
        int   eff, used, exp_hi, got_hi;
        logic occ;
        err = (sl == 0) || (sl < pl);
        eff = err ? ((pl == 0) ? 1 : pl) : sl;
        used = 0; exp_hi = 0; got_hi = 0;
        bit_in = b; bit_valid = v;
        cfg_word = {4'(pl), 4'(sl)};
        #1;
        chk({req, " R2 ready at start"}, int'(bit_ready), 1);
        for (int j = 0; j < eff; j++) begin
            occ = v && (err || m_lfsr[6]) && (used < pl);
            for (int ph = 0; ph < 2 * H; ph++) begin
                @(negedge clk);
                if (j == 0 && ph == 0) begin
                    bit_valid = 0;
                    if (scramble) cfg_word = ~cfg_word;   // R9
                    #1;
                    chk({req, " R3 strobe"}, int'(sym_strobe), 1);
                    chk({req, " R8 err flag"}, int'(cfg_err), int'(err));
                end else begin
                    #1;
                    chk({req, " R3 strobe low"}, int'(sym_strobe), 0);
                end
                chk({req, " R4 R5 pulse"}, int'(pulse_out),
                    int'(occ && ((ph >= H) == b)));
                chk({req, " R2 ready"}, int'(bit_ready),
                    int'((j == eff - 1) && (ph == 2 * H - 1)));
                if (pulse_out) got_hi++;
            end
            if (occ) begin used++; exp_hi += H; end
            m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
        end
        chk({req, " R6 pulse cycles"}, got_hi, exp_hi);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL R2 watchdog: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset(7'h55);
        t_sym(1'b0, 1'b1, 8, 3, 1'b0, "R4 bit0");
        t_sym(1'b1, 1'b1, 8, 3, 1'b0, "R4 bit1");
        t_sym(1'b1, 1'b1, 15, 15, 1'b0, "R5 full");
        t_sym(1'b0, 1'b1, 12, 2, 1'b0, "R6 budget");
        t_sym(1'b1, 1'b1, 5, 0, 1'b0, "R6 zero");
        t_sym(1'b1, 1'b0, 6, 6, 1'b0, "R7 idle");
        t_sym(1'b1, 1'b1, 2, 4, 1'b0, "R8 clamp");
        t_sym(1'b0, 1'b1, 0, 0, 1'b0, "R8 zero");
        t_sym(1'b0, 1'b1, 3, 2, 1'b0, "R8 valid");
        t_sym(1'b1, 1'b1, 9, 4, 1'b1, "R9 scramble");
        t_sym(1'b0, 1'b1, 9, 4, 1'b0, "R9 after");
        t_reset(7'h00);
        t_sym(1'b1, 1'b1, 10, 10, 1'b0, "R5 zero seed");
        t_sym(1'b0, 1'b1, 3, 3, 1'b0, "R2 short");
        t_sym(1'b1, 1'b1, 3, 3, 1'b0, "R2 back");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule